// File: doc/BRIEF.md
# Descriptor Ring Gather Copy Engine

A single copy channel moves data between two descriptor rings in a shared memory. Software sets the base address and the power-of-two size of each ring, fills descriptors, and moves a write index forward on each ring. The engine walks the source ring from its own read index up to the software write index. For each source descriptor it fetches the data buffer word by word and stores it in the destination buffer that software posted on the destination ring.

A source descriptor that carries the chain flag is continued by the next one. All data of a chain is packed back to back into one destination buffer, and one completion follows the last descriptor of the chain. On completion the engine stores the summed byte count together with the transfer tag and the swap flag into the destination descriptor in one word write. It then steps its destination read index and pulses a completion output. Software treats a nonzero count as "done".

A descriptor longer than the programmed maximum is skipped and flagged, and the source index still advances. If the destination ring has no free buffer, the engine waits. Both read indices can be read back through the register port and also appear as outputs.

Top module: `dring_gather_ce`

## Requirements
- R1: After a synchronous active-low reset, both read indices are 0, `xfer_done` and `len_err` are low, no memory request is issued, and the maximum-length register reads 0xFFFF.
- R2: The register port decodes these addresses: 0 source base, 1 source size exponent, 2 source write index, 3 destination base, 4 destination size exponent, 5 destination write index, 6 maximum length, 7 status. Each writable register reads back what was written. A descriptor is two words at base + index*8. Word 0 is the buffer byte address. Word 1 holds the byte count in [15:0] and the flags in [31:16]. Flag bit 0 is chain, flag bit 1 is byte swap, and flag bits [15:4] are the transfer tag.
- R3: A ring of exponent k has 2^k entries. The engine handles source descriptors from its read index up to, but not including, the written source write index. Indices wrap modulo 2^k, and the source index steps by exactly one per descriptor.
- R4: A single unchained descriptor of n bytes copies ceil(n/4) words from its buffer to the start of the destination buffer. The completion count is n.
- R5: A chain of descriptors lands back to back, each piece taking ceil(n/4) words, in one destination buffer. It raises exactly one completion, whose count is the sum of the byte counts and whose tag and swap flag come from the final descriptor.
- R6: A completion is one write of word 1 of the destination descriptor, containing {tag<<4 | swap<<1, count}. In the same cycle `xfer_done` pulses for one cycle and the destination read index steps by one.
- R7: While the destination ring holds no posted buffer, a transfer with data waits. The source index does not pass the waiting descriptor and no completion occurs. The transfer resumes once a buffer is posted.
- R8: A descriptor with the swap flag has the byte order inside each 32-bit word reversed on the way to the destination.
- R9: A descriptor whose count exceeds the maximum-length register copies no data and counts as zero bytes. It pulses `len_err` for one cycle in the same cycle the source index steps past it.
- R10: A transfer whose total count is zero consumes no destination descriptor and raises no completion.
- R11: The status register returns the source read index in bits [7:0] and the destination read index in bits [23:16].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address, word aligned |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Read data, valid one cycle after a read request |
| src_rd_idx | output | IDX_W | Source ring read index |
| dst_rd_idx | output | IDX_W | Destination ring read index |
| xfer_done | output | 1 | One-cycle completion pulse |
| len_err | output | 1 | One-cycle pulse for a skipped oversize descriptor |

## Verification
The assertions watch, on every cycle, that the read indices only ever step by one within the ring mask, and that each completion pulse lines up with a destination index step. They also check that a completion never happens without a posted buffer, that each length error lines up with a source index step, and that reset clears the indices and pulses. Only the bench scenarios can show the data path itself: the words placed in the destination buffer, the byte swap, back-to-back packing of chains, the count and flag word written on completion, the skipping of oversize pieces and the wait on an empty destination ring.

// File: rtl/ce_pkg.sv
// Shared constants and types of the descriptor-ring copy engine.
// Assumes a 32-bit word memory and 16-bit count and flag fields.
package ce_pkg;
    localparam int DATA_W  = 32;
    localparam int AW      = 32;
    localparam int LEN_W   = 16;
    localparam int FLG_W   = 16;
    localparam int REG_AW  = 3;

    // flag field bit positions (decoded by software and by this engine)
    localparam int FLG_CHAIN = 0;
    localparam int FLG_SWAP  = 1;
    localparam logic [FLG_W-1:0] TAG_MASK  = 16'hFFF0;
    localparam logic [FLG_W-1:0] SWAP_MASK = 16'h0002;

    // register addresses
    localparam logic [REG_AW-1:0] RA_SRC_BASE = 3'd0;
    localparam logic [REG_AW-1:0] RA_SRC_EXP  = 3'd1;
    localparam logic [REG_AW-1:0] RA_SRC_WR   = 3'd2;
    localparam logic [REG_AW-1:0] RA_DST_BASE = 3'd3;
    localparam logic [REG_AW-1:0] RA_DST_EXP  = 3'd4;
    localparam logic [REG_AW-1:0] RA_DST_WR   = 3'd5;
    localparam logic [REG_AW-1:0] RA_MAX_LEN  = 3'd6;
    localparam logic [REG_AW-1:0] RA_STATUS   = 3'd7;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SRC_A,
        ST_SRC_B,
        ST_SRC_C,
        ST_DST_WAIT,
        ST_DST_CAP,
        ST_RD,
        ST_WR,
        ST_NEXT,
        ST_WB
    } ce_state_e;
endpackage

// File: rtl/ce_regs.sv
// Register file of the copy engine: ring bases, size exponents, software
// write indices, maximum descriptor length and a read-only status word.
// Assumes IDX_W <= 16 so both indices fit the status word.
module ce_regs
    import ce_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [IDX_W-1:0]  src_rd,
    input  logic [IDX_W-1:0]  dst_rd,
    output logic [AW-1:0]     src_base,
    output logic [AW-1:0]     dst_base,
    output logic [IDX_W-1:0]  src_mask,
    output logic [IDX_W-1:0]  dst_mask,
    output logic [IDX_W-1:0]  src_wr,
    output logic [IDX_W-1:0]  dst_wr,
    output logic [LEN_W-1:0]  max_len
);
    localparam int EXP_W = $clog2(IDX_W + 1);

    logic [EXP_W-1:0] src_exp;
    logic [EXP_W-1:0] dst_exp;

    // register writes from the software port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_base <= '0;
            dst_base <= '0;
            src_exp  <= '0;
            dst_exp  <= '0;
            src_wr   <= '0;
            dst_wr   <= '0;
            max_len  <= '1;
        end else if (reg_we) begin
            case (reg_addr)
                RA_SRC_BASE: src_base <= reg_wdata;
                RA_SRC_EXP:  src_exp  <= reg_wdata[EXP_W-1:0];
                RA_SRC_WR:   src_wr   <= reg_wdata[IDX_W-1:0];
                RA_DST_BASE: dst_base <= reg_wdata;
                RA_DST_EXP:  dst_exp  <= reg_wdata[EXP_W-1:0];
                RA_DST_WR:   dst_wr   <= reg_wdata[IDX_W-1:0];
                RA_MAX_LEN:  max_len  <= reg_wdata[LEN_W-1:0];
                default: ;
            endcase
        end
    end

    // index masks: bit i set when i is below the size exponent
    for (genvar i = 0; i < IDX_W; i++) begin : g_mask
        assign src_mask[i] = (src_exp > EXP_W'(i));
        assign dst_mask[i] = (dst_exp > EXP_W'(i));
    end

    // combinational read mux
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_SRC_BASE: reg_rdata = src_base;
            RA_SRC_EXP:  reg_rdata[EXP_W-1:0] = src_exp;
            RA_SRC_WR:   reg_rdata[IDX_W-1:0] = src_wr;
            RA_DST_BASE: reg_rdata = dst_base;
            RA_DST_EXP:  reg_rdata[EXP_W-1:0] = dst_exp;
            RA_DST_WR:   reg_rdata[IDX_W-1:0] = dst_wr;
            RA_MAX_LEN:  reg_rdata[LEN_W-1:0] = max_len;
            default: begin
                reg_rdata[IDX_W-1:0]     = src_rd;
                reg_rdata[16 +: IDX_W]   = dst_rd;
            end
        endcase
    end
endmodule

// File: rtl/ce_ring_ptr.sv
// Read pointer of one descriptor ring. Steps by one modulo the ring size
// and flags when software has entries beyond it. Assumes the mask is
// 2^k - 1 and the software write index stays within the ring.
module ce_ring_ptr #(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] mask,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             step,
    output logic [IDX_W-1:0] rd_idx,
    output logic             pending
);
    // pointer advance with wrap
    always_ff @(posedge clk) begin
        if (!rst_n) rd_idx <= '0;
        else if (step) rd_idx <= (rd_idx + 1'b1) & mask;
    end

    assign pending = (rd_idx != (wr_idx & mask));
endmodule

// File: rtl/ce_byteswap.sv
// Optional byte-order reversal of one data word. Assumes whole bytes.
module ce_byteswap #(
    parameter int BYTES = 4
) (
    input  logic               en,
    input  logic [8*BYTES-1:0] din,
    output logic [8*BYTES-1:0] dout
);
    logic [8*BYTES-1:0] rev;

    for (genvar b = 0; b < BYTES; b++) begin : g_byte
        assign rev[8*b +: 8] = din[8*(BYTES-1-b) +: 8];
    end

    assign dout = en ? rev : din;
endmodule

// File: rtl/ce_engine.sv
// Copy sequencer: fetches source descriptors, copies their buffers word
// by word into a posted destination buffer, packs chained pieces back to
// back and writes the count/flag word once per transfer.
// Assumes a memory with one-cycle read latency that accepts every request,
// and transfer totals that fit in 16 bits.
module ce_engine
    import ce_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     src_base,
    input  logic [AW-1:0]     dst_base,
    input  logic [IDX_W-1:0]  src_mask,
    input  logic [IDX_W-1:0]  dst_mask,
    input  logic [IDX_W-1:0]  src_wr,
    input  logic [IDX_W-1:0]  dst_wr,
    input  logic [LEN_W-1:0]  max_len,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [IDX_W-1:0]  src_rd,
    output logic [IDX_W-1:0]  dst_rd,
    output logic              xfer_done,
    output logic              len_err
);
    localparam int WCNT_W = LEN_W - 1;
    localparam int BYTES  = DATA_W / 8;

    ce_state_e          st;
    logic [AW-1:0]      cur_addr;
    logic [AW-1:0]      dst_buf;
    logic [LEN_W-1:0]   cur_len;
    logic [LEN_W-1:0]   total;
    logic [FLG_W-1:0]   cur_flags;
    logic               cur_over;
    logic [WCNT_W-1:0]  wcnt;
    logic [WCNT_W-1:0]  nwords;
    logic [LEN_W-1:0]   dst_off;
    logic               have_dst;

    logic               src_pend;
    logic               dst_pend;
    logic               src_step;
    logic               dst_step;
    logic [AW-1:0]      src_desc;
    logic [AW-1:0]      dst_desc;
    logic [LEN_W-1:0]   in_len;
    logic               in_over;
    logic [LEN_W-1:0]   in_eff;
    logic [LEN_W:0]     in_round;
    logic [LEN_W-1:0]   total_n;
    logic [FLG_W-1:0]   out_flags;
    logic [DATA_W-1:0]  swapped;

    ce_ring_ptr #(.IDX_W(IDX_W)) u_src_ptr (
        .clk(clk), .rst_n(rst_n), .mask(src_mask), .wr_idx(src_wr),
        .step(src_step), .rd_idx(src_rd), .pending(src_pend)
    );

    ce_ring_ptr #(.IDX_W(IDX_W)) u_dst_ptr (
        .clk(clk), .rst_n(rst_n), .mask(dst_mask), .wr_idx(dst_wr),
        .step(dst_step), .rd_idx(dst_rd), .pending(dst_pend)
    );

    ce_byteswap #(.BYTES(BYTES)) u_swap (
        .en(cur_flags[FLG_SWAP]), .din(mem_rdata), .dout(swapped)
    );

    // descriptor addresses, length decode and completion word fields
    assign src_desc  = src_base + AW'({src_rd, 3'b000});
    assign dst_desc  = dst_base + AW'({dst_rd, 3'b000});
    assign in_len    = mem_rdata[LEN_W-1:0];
    assign in_over   = (in_len > max_len);
    assign in_eff    = in_over ? '0 : in_len;
    assign in_round  = {1'b0, in_eff} + (LEN_W+1)'(3);
    assign total_n   = total + cur_len;
    assign out_flags = (cur_flags & TAG_MASK) | (cur_flags & SWAP_MASK);
    assign src_step  = (st == ST_NEXT);
    assign dst_step  = (st == ST_WB);

    // memory request generation per state
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (st)
            ST_SRC_A: begin
                mem_req  = 1'b1;
                mem_addr = src_desc;
            end
            ST_SRC_B: begin
                mem_req  = 1'b1;
                mem_addr = src_desc + AW'(4);
            end
            ST_DST_WAIT: begin
                mem_req  = dst_pend;
                mem_addr = dst_desc;
            end
            ST_RD: begin
                mem_req  = 1'b1;
                mem_addr = cur_addr + AW'({wcnt, 2'b00});
            end
            ST_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = dst_buf + AW'({dst_off, 2'b00});
                mem_wdata = swapped;
            end
            ST_WB: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = dst_desc + AW'(4);
                mem_wdata = {out_flags, total};
            end
            default: ;
        endcase
    end

    // sequencer state, descriptor capture and transfer bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            cur_addr  <= '0;
            dst_buf   <= '0;
            cur_len   <= '0;
            total     <= '0;
            cur_flags <= '0;
            cur_over  <= 1'b0;
            wcnt      <= '0;
            nwords    <= '0;
            dst_off   <= '0;
            have_dst  <= 1'b0;
            xfer_done <= 1'b0;
            len_err   <= 1'b0;
        end else begin
            xfer_done <= 1'b0;
            len_err   <= 1'b0;
            case (st)
                ST_IDLE: if (src_pend) st <= ST_SRC_A;
                ST_SRC_A: st <= ST_SRC_B;
                ST_SRC_B: begin
                    cur_addr <= mem_rdata;
                    st       <= ST_SRC_C;
                end
                ST_SRC_C: begin
                    cur_flags <= mem_rdata[DATA_W-1:LEN_W];
                    cur_len   <= in_eff;
                    cur_over  <= in_over;
                    nwords    <= in_round[LEN_W:2];
                    wcnt      <= '0;
                    if (in_eff == '0) st <= ST_NEXT;
                    else if (have_dst) st <= ST_RD;
                    else st <= ST_DST_WAIT;
                end
                ST_DST_WAIT: if (dst_pend) st <= ST_DST_CAP;
                ST_DST_CAP: begin
                    dst_buf  <= mem_rdata;
                    have_dst <= 1'b1;
                    dst_off  <= '0;
                    st       <= ST_RD;
                end
                ST_RD: st <= ST_WR;
                ST_WR: begin
                    wcnt    <= wcnt + 1'b1;
                    dst_off <= dst_off + 1'b1;
                    st      <= ((wcnt + 1'b1) == nwords) ? ST_NEXT : ST_RD;
                end
                ST_NEXT: begin
                    len_err <= cur_over;
                    if (cur_flags[FLG_CHAIN]) begin
                        total <= total_n;
                        st    <= ST_IDLE;
                    end else if (total_n != '0) begin
                        total <= total_n;
                        st    <= ST_WB;
                    end else begin
                        total <= '0;
                        st    <= ST_IDLE;
                    end
                end
                ST_WB: begin
                    xfer_done <= 1'b1;
                    have_dst  <= 1'b0;
                    total     <= '0;
                    st        <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dring_gather_ce.sv
// Top of the single-channel descriptor-ring copy engine with chaining.
// Assumes software keeps one ring slot free and posts descriptors in
// memory before moving a write index.
module dring_gather_ce
    import ce_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [IDX_W-1:0]  src_rd_idx,
    output logic [IDX_W-1:0]  dst_rd_idx,
    output logic              xfer_done,
    output logic              len_err
);
    logic [AW-1:0]     src_base;
    logic [AW-1:0]     dst_base;
    logic [IDX_W-1:0]  src_mask;
    logic [IDX_W-1:0]  dst_mask;
    logic [IDX_W-1:0]  src_wr;
    logic [IDX_W-1:0]  dst_wr;
    logic [LEN_W-1:0]  max_len;

    ce_regs #(.IDX_W(IDX_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .src_rd(src_rd_idx), .dst_rd(dst_rd_idx),
        .src_base(src_base), .dst_base(dst_base),
        .src_mask(src_mask), .dst_mask(dst_mask),
        .src_wr(src_wr), .dst_wr(dst_wr), .max_len(max_len)
    );

    ce_engine #(.IDX_W(IDX_W)) u_engine (
        .clk(clk), .rst_n(rst_n),
        .src_base(src_base), .dst_base(dst_base),
        .src_mask(src_mask), .dst_mask(dst_mask),
        .src_wr(src_wr), .dst_wr(dst_wr), .max_len(max_len),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .src_rd(src_rd_idx), .dst_rd(dst_rd_idx),
        .xfer_done(xfer_done), .len_err(len_err)
    );
endmodule

// File: rtl/ce_checker.sv
// Property checker for dring_gather_ce, attached by bind below.
module ce_checker #(
    parameter int IDX_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             xfer_done,
    input logic             len_err,
    input logic [IDX_W-1:0] src_rd_idx,
    input logic [IDX_W-1:0] dst_rd_idx,
    input logic [IDX_W-1:0] src_mask,
    input logic [IDX_W-1:0] dst_mask,
    input logic [IDX_W-1:0] dst_wr
);
    // reset clears indices and pulses
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (src_rd_idx == '0 && dst_rd_idx == '0 && !xfer_done && !len_err));

    // source index only steps by one within the ring
    p_src_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (src_rd_idx != $past(src_rd_idx)) |->
        (src_rd_idx == (($past(src_rd_idx) + 1'b1) & $past(src_mask))));

    // completion coincides with one destination step
    p_done_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> (dst_rd_idx == (($past(dst_rd_idx) + 1'b1) & $past(dst_mask))));

    // completion pulse lasts one cycle and never meets an error pulse
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> !xfer_done);
    p_pulse_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(xfer_done && len_err));

    // no completion unless a destination buffer was posted
    p_done_needs_buf_r7: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> $past(dst_rd_idx != (dst_wr & dst_mask)));

    // error pulse coincides with the source step past the skipped entry
    p_err_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        len_err |-> (src_rd_idx == (($past(src_rd_idx) + 1'b1) & $past(src_mask))));
endmodule

bind dring_gather_ce ce_checker #(.IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .xfer_done(xfer_done), .len_err(len_err),
    .src_rd_idx(src_rd_idx), .dst_rd_idx(dst_rd_idx),
    .src_mask(src_mask), .dst_mask(dst_mask), .dst_wr(dst_wr)
);

// File: tb/dring_gather_ce_tb.sv
`timescale 1ns/1ps
module dring_gather_ce_tb;
    localparam int IDX_W = 8;
    localparam int SRC_MSK = 7;
    localparam int DST_MSK = 3;
    localparam int MAXL = 64;
    localparam logic [31:0] SRC_RING = 32'h0000;
    localparam logic [31:0] DST_RING = 32'h0100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_we = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [IDX_W-1:0] src_rd_idx, dst_rd_idx;
    logic xfer_done, len_err;

    logic [31:0] mem [0:4095];
    logic bw_en = 1'b0;
    logic [11:0] bw_a = '0;
    logic [31:0] bw_d = '0;

    int n_chk = 0, n_err = 0, n_done = 0, n_errp = 0;
    int sw_src = 0, sw_dst = 0, xfer_no = 0;
    int p_len [4];
    bit p_swp [4];
    logic [31:0] exp_w [64];

    always #2 clk = ~clk;

    dring_gather_ce #(.IDX_W(IDX_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .src_rd_idx(src_rd_idx), .dst_rd_idx(dst_rd_idx),
        .xfer_done(xfer_done), .len_err(len_err)
    );

    // shared memory model, one-cycle read latency, plus bench write path
    always @(posedge clk) begin
        if (bw_en) mem[bw_a] <= bw_d;
        if (mem_req && mem_we) mem[mem_addr[13:2]] <= mem_wdata;
        if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[13:2]];
    end

    // pulse counters
    always @(posedge clk) begin
        if (rst_n && xfer_done) n_done <= n_done + 1;
        if (rst_n && len_err) n_errp <= n_errp + 1;
    end

    function automatic logic [31:0] bswap(input logic [31:0] d);
        return {d[7:0], d[15:8], d[23:16], d[31:24]};
    endfunction

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic poke(input logic [31:0] a, input logic [31:0] d);
        bw_en = 1'b1; bw_a = a[13:2]; bw_d = d;
        @(negedge clk);
        bw_en = 1'b0;
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic post_dst(input logic [31:0] bufa);
        logic [31:0] da;
        da = DST_RING + 32'(sw_dst * 8);
        poke(da, bufa);
        poke(da + 4, 32'h0);
        sw_dst = (sw_dst + 1) & DST_MSK;
        reg_wr(3'd5, 32'(sw_dst));
    endtask

    task automatic wait_src(input int target);
        for (int k = 0; k < 3000 && src_rd_idx != 8'(target); k++) @(negedge clk);
        repeat (6) @(negedge clk);
    endtask

    // post one chain of n pieces from p_len/p_swp, run it and check it
    task automatic run_chain(input int n, input int meta, input bit stall, input string req);
        int tot, nw, nerr_exp, src0, dsc, done0, err0;
        logic [31:0] bufa, d, pa, w1;
        logic [15:0] flg;
        tot = 0; nw = 0; nerr_exp = 0;
        bufa = 32'h2000 + 32'((xfer_no % 16) * 256);
        xfer_no++;
        for (int i = 0; i < n; i++) begin
            pa = 32'h1000 + 32'(i * 128);
            if (p_len[i] > MAXL) nerr_exp++;
            else begin
                tot += p_len[i];
                for (int w = 0; w < (p_len[i] + 3) / 4; w++) begin
                    d = $urandom;
                    poke(pa + 32'(w * 4), d);
                    exp_w[nw] = p_swp[i] ? bswap(d) : d;
                    nw++;
                end
            end
        end
        src0 = sw_src;
        for (int i = 0; i < n; i++) begin
            pa = 32'h1000 + 32'(i * 128);
            flg = 16'((meta & 12'hFFF) << 4) | 16'(p_swp[i] << 1) | 16'(i < n - 1);
            poke(SRC_RING + 32'(sw_src * 8), pa);
            poke(SRC_RING + 32'(sw_src * 8) + 4, {flg, 16'(p_len[i])});
            sw_src = (sw_src + 1) & SRC_MSK;
        end
        done0 = n_done; err0 = n_errp; dsc = sw_dst;
        if (tot > 0 && !stall) post_dst(bufa);
        reg_wr(3'd2, 32'(sw_src));
        if (stall) begin
            repeat (60) @(negedge clk);
            chk("R7", "source index held without buffer", src_rd_idx, src0);
            chk("R7", "no completion without buffer", n_done - done0, 0);
            post_dst(bufa);
        end
        wait_src(sw_src);
        chk("R9", "length error pulses", n_errp - err0, nerr_exp);
        if (tot > 0) begin
            w1 = mem[(DST_RING[13:2] + 12'(dsc * 2) + 12'd1)];
            chk(req, "completion byte count", w1[15:0], tot);
            chk(req, "completion flags", w1[31:16], ((meta & 12'hFFF) << 4) | (p_swp[n-1] << 1));
            for (int w = 0; w < nw; w++)
                chk(req, "destination data word", mem[bufa[13:2] + 12'(w)], exp_w[w]);
            chk("R6", "one completion per transfer", n_done - done0, 1);
            chk("R6", "destination index stepped", dst_rd_idx, sw_dst);
        end else begin
            chk("R10", "no completion for empty transfer", n_done - done0, 0);
            chk("R10", "destination index kept", dst_rd_idx, sw_dst);
        end
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected end of run");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", "source index after reset", src_rd_idx, 0);
        chk("R1", "destination index after reset", dst_rd_idx, 0);
        chk("R1", "no pulses after reset", {xfer_done, len_err}, 0);
        chk("R1", "no memory request after reset", mem_req, 0);
        reg_rd(3'd6, rd);
        chk("R1", "maximum length reset value", rd, 32'hFFFF);

        // R2: configuration and readback
        reg_wr(3'd0, SRC_RING);
        reg_wr(3'd1, 32'd3);
        reg_wr(3'd3, DST_RING);
        reg_wr(3'd4, 32'd2);
        reg_wr(3'd6, 32'(MAXL));
        reg_rd(3'd1, rd);
        chk("R2", "source size exponent readback", rd, 3);
        reg_rd(3'd3, rd);
        chk("R2", "destination base readback", rd, DST_RING);

        // R4: single descriptor, whole words
        p_len[0] = 12; p_swp[0] = 0;
        run_chain(1, 12'h05A, 0, "R4");
        // R4: odd length rounds up to whole words
        p_len[0] = 7; p_swp[0] = 0;
        run_chain(1, 12'h001, 0, "R4");
        // R8: byte swap
        p_len[0] = 16; p_swp[0] = 1;
        run_chain(1, 12'h3C3, 0, "R8");
        // R5: chain of three packed back to back
        p_len[0] = 8; p_len[1] = 4; p_len[2] = 12;
        p_swp[0] = 0; p_swp[1] = 1; p_swp[2] = 0;
        run_chain(3, 12'hABC, 0, "R5");
        // R9: oversize piece inside a chain is skipped
        p_len[0] = 8; p_len[1] = 100; p_len[2] = 4;
        p_swp[0] = 0; p_swp[1] = 0; p_swp[2] = 1;
        run_chain(3, 12'h777, 0, "R9");
        // R10: lone oversize descriptor
        p_len[0] = 200; p_swp[0] = 0;
        run_chain(1, 12'h010, 0, "R10");
        // R7: wait on an empty destination ring
        p_len[0] = 20; p_len[1] = 8; p_swp[0] = 1; p_swp[1] = 0;
        run_chain(2, 12'h0F0, 1, "R7");

        // R5: random chains mixed with oversize pieces and swaps
        for (int t = 0; t < 40; t++) begin
            int n;
            n = 1 + int'($urandom % 3);
            for (int i = 0; i < n; i++) begin
                p_len[i] = ($urandom % 8 == 0) ? 65 + int'($urandom % 16) : 1 + int'($urandom % 40);
                p_swp[i] = $urandom % 2;
            end
            run_chain(n, int'($urandom % 4096), 0, "R5");
        end

        // R3: indices wrapped and track the written indices
        chk("R3", "source index after wraps", src_rd_idx, sw_src);
        chk("R3", "destination index after wraps", dst_rd_idx, sw_dst);
        // R11: status word
        reg_rd(3'd7, rd);
        chk("R11", "status word", rd, (sw_dst << 16) | sw_src);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule